// File: doc/BRIEF.md
# Tuning Control Two-Wire Receiver

This block is a write-only slave on a two-wire serial bus. It holds the tuning word and the operating mode of an RF modulator's frequency synthesizer. It samples the bus clock and data lines into the system clock and recognises start, repeated-start and stop conditions. It responds only to one fixed address byte, which has the write direction bit clear. After that address it accepts any number of data bytes and acknowledges each one by pulling the data line low during the ninth clock.

There is no sub-address. The most significant bit of each data byte selects which half of the settings the byte loads. A byte with that bit clear carries the upper seven bits of the 10-bit divider word. A byte with that bit set carries the lower three divider bits, a 3-bit test code and the output-port control bit. Either byte may be sent on its own. The test code is decoded into eight one-hot mode enables. A `configured` flag stays low after reset until both kinds of byte have been received.

Top module: `tuner_ctl_rx`

## Requirements
- R1: After reset the divider word, the test code and the port bit are zero. `configured_o` is low, only `mode_en_o[0]` is high, and `sda_drive_o` is low.
- R2: The address byte 0xC8 is acknowledged: `sda_drive_o` is high while SCL is high for the ninth clock. Any other address byte is not acknowledged, including 0xC9, which has the read bit set.
- R3: After a non-matching address, no later byte of that transfer is acknowledged, and no output changes.
- R4: After a matching address, every data byte is acknowledged during its ninth clock.
- R5: A data byte with bit 7 = 0 loads its bits 6..0 into `div_o[9:3]`. All other outputs keep their values.
- R6: A data byte with bit 7 = 1 loads the following fields: bit 6 into `test_code_o[2]`, bit 5 into `test_code_o[1]`, bit 4 into `test_code_o[0]`, bit 3 into `port_on_o`, and bits 2..0 into `div_o[2:0]`. `div_o[9:3]` is left unchanged.
- R7: `mode_en_o` is one-hot, with bit index equal to `test_code_o`. The meaning of each index:
  - 0: normal operation
  - 1: test pattern
  - 2: RF oscillator off
  - 3: balance test
  - 4: reference frequency out
  - 5: high-impedance test
  - 6: divided frequency out
  - 7: phase detector off, with baseband on the RF outputs
- R8: `port_on_o` = 1 means the open-collector port sinks current. `port_on_o` = 0 leaves the port off.
- R9: `configured_o` stays low until at least one byte of each kind has been received since reset. After that it stays high until the next reset.
- R10: `sda_drive_o` changes only while the synchronised SCL is low. It is low after a stop condition.
- R11: Data bytes may come in either order within one transfer. A repeated start returns the receiver to the address phase.
- R12: Outputs change only when a data byte is taken, which happens on the SCL falling edge that ends its eighth bit. They are stable at all other times, including during the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| div_o | output | 10 | Programmable divider word, bit 9 most significant |
| test_code_o | output | 3 | Test code, bit 2 = first transmitted test bit |
| mode_en_o | output | 8 | One-hot decoded mode enables |
| port_on_o | output | 1 | Output-port sink enable |
| configured_o | output | 1 | Both kinds of byte have been received since reset |

## Verification
The assertions check on every cycle that the outputs change only when a byte is taken. They also check that each kind of byte loads exactly its own fields, that the acknowledge drive moves only while SCL is low and is released by a stop, and that `configured` rises only when a byte arrives. Only the bench scenarios can show which address bytes get an acknowledge. The same holds for the silence of a transfer after a wrong address, the full table of mode codes, the behaviour of mixed orders and repeated starts within one transfer, and the return of `configured` to low on a reset in mid-use.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 10;
  localparam int HI_W   = BYTE_W - 1;
  localparam int LO_W   = DIV_W - HI_W;
  localparam int CODE_W = 3;
  localparam int MODES  = 1 << CODE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK} phase_e;

  // Bit 7 picks the register half a data byte belongs to.
  function automatic logic f_is_mode_byte(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [MODES-1:0] f_mode_onehot(input logic [CODE_W-1:0] code);
    logic [MODES-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // Lines idle high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tcr_link.sv
module tcr_link
  import tcr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  output logic              start_ev,
  output logic              stop_ev,
  output logic              sda_drive_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  phase_e             phase;
  logic               addressed;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;
  logic               scl_d, sda_d;
  logic               scl_rise, scl_fall;

  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
  assign byte_o   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      addressed   <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      sda_drive_o <= 1'b0;
      byte_stb_o  <= 1'b0;
      scl_d       <= 1'b1;
      sda_d       <= 1'b1;
    end else begin
      scl_d      <= scl_q;
      sda_d      <= sda_q;
      byte_stb_o <= 1'b0;
      if (stop_ev) begin
        phase       <= PH_IDLE;
        sda_drive_o <= 1'b0;
      end else if (start_ev) begin
        phase       <= PH_RX;
        addressed   <= 1'b0;
        bit_cnt     <= '0;
        sda_drive_o <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && bit_cnt < LAST) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_q};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST) begin
              if (addressed || shreg == ADDR) begin
                sda_drive_o <= 1'b1;
                phase       <= PH_ACK;
                addressed   <= 1'b1;
                byte_stb_o  <= addressed;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_drive_o <= 1'b0;
              bit_cnt     <= '0;
              phase       <= PH_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcr_regs.sv
module tcr_regs
  import tcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CODE_W-1:0] test_code_o,
  output logic [MODES-1:0]  mode_en_o,
  output logic              port_on_o,
  output logic              configured_o
);
  logic [HI_W-1:0] div_hi;
  logic [LO_W-1:0] div_lo;
  logic            seen_hi, seen_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_hi      <= '0;
      div_lo      <= '0;
      test_code_o <= '0;
      port_on_o   <= 1'b0;
      seen_hi     <= 1'b0;
      seen_lo     <= 1'b0;
    end else if (byte_stb) begin
      if (!f_is_mode_byte(byte_i)) begin
        div_hi  <= byte_i[HI_W-1:0];
        seen_hi <= 1'b1;
      end else begin
        test_code_o <= byte_i[BYTE_W-2 -: CODE_W];
        port_on_o   <= byte_i[LO_W];
        div_lo      <= byte_i[LO_W-1:0];
        seen_lo     <= 1'b1;
      end
    end
  end

  assign div_o        = {div_hi, div_lo};
  assign mode_en_o    = f_mode_onehot(test_code_o);
  assign configured_o = seen_hi & seen_lo;
endmodule

// File: rtl/tuner_ctl_rx.sv
module tuner_ctl_rx
  import tcr_pkg::*;
#(
  parameter logic [7:0] ADDR        = 8'hC8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_drive_o,
  output logic [9:0]  div_o,
  output logic [2:0]  test_code_o,
  output logic [7:0]  mode_en_o,
  output logic        port_on_o,
  output logic        configured_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  line_raw, line_q;
  logic              scl_q, sda_q;
  logic              start_ev, stop_ev;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    tcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_raw[g]),
      .q    (line_q[g])
    );
  end

  assign scl_q = line_q[0];
  assign sda_q = line_q[1];

  tcr_link #(.ADDR(ADDR)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_q      (scl_q),
    .sda_q      (sda_q),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sda_drive_o(sda_drive_o),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_q)
  );

  tcr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_stb    (byte_stb),
    .byte_i      (byte_q),
    .div_o       (div_o),
    .test_code_o (test_code_o),
    .mode_en_o   (mode_en_o),
    .port_on_o   (port_on_o),
    .configured_o(configured_o)
  );
endmodule

// File: rtl/tcr_chk.sv
module tcr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       stop_ev,
  input logic       byte_stb,
  input logic [7:0] byte_q,
  input logic       sda_drive_o,
  input logic [9:0] div_o,
  input logic [2:0] test_code_o,
  input logic       port_on_o,
  input logic       configured_o
);
  AST_HOLD_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> ($stable(div_o) && $stable(test_code_o) && $stable(port_on_o) && $stable(configured_o))); // R12

  AST_DIV_HI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !byte_q[7]) |=> (div_o[9:3] == $past(byte_q[6:0]) && $stable(div_o[2:0]) && $stable(test_code_o))); // R5

  AST_MODE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_q[7]) |=> ({test_code_o, port_on_o, div_o[2:0]} == $past(byte_q[6:0]) && $stable(div_o[9:3]))); // R6

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_o) |-> !$past(scl_q)); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_drive_o); // R10

  AST_CFG_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured_o) |-> $past(byte_stb)); // R9
endmodule

bind tuner_ctl_rx tcr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_q       (scl_q),
  .stop_ev     (stop_ev),
  .byte_stb    (byte_stb),
  .byte_q      (byte_q),
  .sda_drive_o (sda_drive_o),
  .div_o       (div_o),
  .test_code_o (test_code_o),
  .port_on_o   (port_on_o),
  .configured_o(configured_o)
);

// File: tb/test_tuner_ctl_rx.sv
module test_tuner_ctl_rx;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_drive_o;
  logic [9:0] div_o;
  logic [2:0] test_code_o;
  logic [7:0] mode_en_o;
  logic       port_on_o;
  logic       configured_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [6:0] m_hi;
  logic [2:0] m_lo;
  logic [2:0] m_code;
  logic       m_port, m_seen_hi, m_seen_lo;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_o;

  tuner_ctl_rx i_tuner_ctl_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_o(sda_drive_o), .div_o(div_o), .test_code_o(test_code_o),
    .mode_en_o(mode_en_o), .port_on_o(port_on_o), .configured_o(configured_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic model_reset();
    m_hi = '0; m_lo = '0; m_code = '0; m_port = 1'b0;
    m_seen_hi = 1'b0; m_seen_lo = 1'b0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (b[7] == 1'b0) begin
      m_hi = b[6:0]; m_seen_hi = 1'b1;
    end else begin
      m_code = {b[6], b[5], b[4]}; m_port = b[3]; m_lo = b[2:0]; m_seen_lo = 1'b1;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " div"}, 32'(div_o), 32'({m_hi, m_lo}));
    chk({tag, " code"}, 32'(test_code_o), 32'(m_code));
    chk({tag, " port"}, 32'(port_on_o), 32'(m_port));
    chk({tag, " modes"}, 32'(mode_en_o), 32'(8'd1 << m_code));
    chk({tag, " configured"}, 32'(configured_o), 32'(m_seen_hi & m_seen_lo));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = ~sda_bus;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic t_reset();
    model_reset();
    check_all("R1");
    chk("R1 sda drive", 32'(sda_drive_o), 0);
  endtask

  task automatic t_hi_only();
    logic a;
    bus_start();
    send_byte(8'hC8, a); chk("R2 address acked", 32'(a), 1);
    check_all("R12 after address");
    send_byte(8'h3A, a); chk("R4 data acked", 32'(a), 1);
    model_byte(8'h3A);
    bus_stop();
    check_all("R5 high byte alone");
    chk("R9 only one kind", 32'(configured_o), 0);
    chk("R10 released after stop", 32'(sda_drive_o), 0);
  endtask

  task automatic t_lo_only();
    logic a;
    bus_start();
    send_byte(8'hC8, a);
    send_byte(8'h87, a); chk("R4 mode byte acked", 32'(a), 1);
    model_byte(8'h87);
    bus_stop();
    check_all("R6 mode byte alone");
    chk("R6 divider word", 32'(div_o), 471);
    chk("R9 both kinds", 32'(configured_o), 1);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'hCA, a); chk("R2 wrong address", 32'(a), 0);
    send_byte(8'hF7, a); chk("R3 data after wrong address", 32'(a), 0);
    send_byte(8'h11, a); chk("R3 second data after wrong address", 32'(a), 0);
    bus_stop();
    check_all("R3 unchanged");
    bus_start();
    send_byte(8'hC9, a); chk("R2 read address", 32'(a), 0);
    send_byte(8'h05, a);
    bus_stop();
    check_all("R3 unchanged after read address");
  endtask

  task automatic t_modes();
    logic a;
    for (int c = 0; c < 8; c++) begin
      logic [7:0] b;
      b = {1'b1, 3'(c), c[0], 3'(7 - c)};
      bus_start();
      send_byte(8'hC8, a);
      send_byte(b, a);
      bus_stop();
      model_byte(b);
      chk($sformatf("R7 mode enable code %0d", c), 32'(mode_en_o), 32'(8'd1 << c));
      chk($sformatf("R8 port code %0d", c), 32'(port_on_o), 32'(c[0]));
      chk("R6 low divider bits", 32'(div_o[2:0]), 32'(7 - c));
    end
  endtask

  task automatic t_order_rs();
    logic a;
    bus_start();
    send_byte(8'hC8, a);
    send_byte(8'hF5, a); chk("R11 mode byte first", 32'(a), 1);
    send_byte(8'h01, a); chk("R11 high byte second", 32'(a), 1);
    model_byte(8'hF5); model_byte(8'h01);
    bus_start();
    send_byte(8'h55, a); chk("R11 repeated start to wrong address", 32'(a), 0);
    bus_start();
    send_byte(8'hC8, a); chk("R11 repeated start address", 32'(a), 1);
    send_byte(8'h7F, a);
    model_byte(8'h7F);
    bus_stop();
    check_all("R11 mixed transfer");
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 1'b0; wq(); rst_n = 1'b1; wq();
    model_reset();
    check_all("R9 reset clears");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    t_reset();
    t_hi_only();
    t_lo_only();
    t_bad_addr();
    t_modes();
    t_order_rs();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule